// File: doc/BRIEF.md
# Key-Matrix GPIO Port Bank

This block gives a small microcontroller four 4-bit pin groups for scanning a key matrix. The first group only senses. The second sets its direction pin by pin. The third and fourth each switch all four pins together. When a pin acts as an output it can only pull the line low or let it float. A pull-up is enabled only while the pin is an input. Software reaches the output latches and the direction settings through a simple register bus. The bus has two spaces: a banked data space for the port values and a register-file space for the directions.

Reading a port returns the latch for pins configured as outputs and the synchronized pad level for pins configured as inputs. The block combines all input pins into one wake request for the standby controller. The request is raised whenever any pin that is currently sensing is seen low. During a key scan, the output pins drive the matrix columns low one at a time, and any pressed key pulls a sensing row low.

Top module: `keymat_port_bank`

## Requirements
- R1: Reset state. The direction bit is 1 for output and 0 for input. After synchronous reset, every output latch is 0. The second port's four pins are inputs. The third and fourth ports are outputs, so `pad_od_low` reads 16'hFF00 and `pad_pu_en` reads 16'h00FF.
- R2: The first port is read at data address 0x70 in bank 0. Writes to that address change nothing. Its pins always have the pull-up enabled and are never driven low.
- R3: The second port's direction is held per pin in bits 3:0 of register-file address 0x26. Bit n controls pin n. The register reads back as written.
- R4: Register-file address 0x37 sets a whole port's direction. Bit 2 controls the third port and bit 3 controls the fourth. Bits 1:0 always read 0, and writing them has no effect.
- R5: A pin in output mode asserts `pad_od_low` exactly when its latch bit is 0, and its `pad_pu_en` is 0. A pin in input mode has `pad_pu_en` = 1 and `pad_od_low` = 0.
- R6: Data addresses 0x71, 0x72 and 0x73 in bank 0 hold the latches of ports two, three and four. Reading such an address returns the latch bit for output pins and the synchronized pad level for input pins.
- R7: A data write loads the port's latch whether the port is an input or an output. After a later switch to output mode, the stored value shows on the pads.
- R8: `wake_req` is 1 exactly when at least one synchronized input-mode pin is low. Output-mode pins never contribute.
- R9: Every pad input passes through two flip-flops. A change becomes visible to reads and to `wake_req` after the second rising clock edge that follows it, and not after the first.
- R10: Unmapped addresses and data accesses outside bank 0 read 0 and change nothing. This includes 0x70–0x73 in other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_rf | input | 1 | 1 selects the register-file space, 0 the data space |
| bus_bank | input | 2 | Data-space bank number |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Combinational read data for the current address |
| pin_in | input | 16 | Pad levels, port n on bits 4n+3:4n |
| pad_od_low | output | 16 | 1 enables the low-side driver of that pad |
| pad_pu_en | output | 16 | 1 enables the pad pull-up |
| wake_req | output | 1 | Standby wake request |

## Verification
A corrupted direction register shows up right away at the pad controls. The affected pin's pull-up and its low driver switch together. A read of that port then returns the latch where the pad level was expected, or the reverse. A stale synchronizer stage is visible as a read or wake value that lags the pad by one or three edges instead of two, so the bench samples exactly two edges after every pad change. A latch that ignores writes made in input mode stays hidden until the port is switched to output mode. The bench therefore writes in input mode and then flips the direction.

// File: rtl/kmp_pkg.sv
package kmp_pkg;
    localparam int PW     = 4;
    localparam int NPORT  = 4;
    localparam int ADDR_W = 8;
    localparam int BANK_W = 2;
    localparam int PINS   = PW * NPORT;

    localparam logic [ADDR_W-1:0] DM_BASE  = 8'h70;
    localparam logic [ADDR_W-1:0] RF_DIRB  = 8'h26;
    localparam logic [ADDR_W-1:0] RF_GROUP = 8'h37;
    localparam int GRP_C_BIT = 2;
    localparam int GRP_D_BIT = 3;

    typedef enum logic [1:0] {
        PORT_SENSE = 2'd0,
        PORT_BITDIR = 2'd1,
        PORT_GRP_C = 2'd2,
        PORT_GRP_D = 2'd3
    } port_e;

    typedef struct packed {
        logic  dm_hit;
        port_e port;
        logic  rf_dirb;
        logic  rf_group;
    } dec_t;

    function automatic dec_t decode(input logic rf,
                                    input logic [BANK_W-1:0] bank,
                                    input logic [ADDR_W-1:0] addr);
        dec_t d;
        d = '0;
        if (rf) begin
            d.rf_dirb  = (addr == RF_DIRB);
            d.rf_group = (addr == RF_GROUP);
        end else if (bank == '0 && addr[ADDR_W-1:2] == DM_BASE[ADDR_W-1:2]) begin
            d.dm_hit = 1'b1;
            d.port   = port_e'(addr[1:0]);
        end
        return d;
    endfunction
endpackage

// File: rtl/kmp_sync.sv
module kmp_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            stab_q <= '1;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/kmp_dir_regs.sv
module kmp_dir_regs
    import kmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_dirb,
    input  logic            wr_group,
    input  logic [PW-1:0]   wdata,
    output logic [PINS-1:0] dir_flat,
    output logic [PW-1:0]   rd_dirb,
    output logic [PW-1:0]   rd_group
);
    logic [PW-1:0] dirb_q;
    logic          dirc_q;
    logic          dird_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dirb_q <= '0;
            dirc_q <= 1'b1;
            dird_q <= 1'b1;
        end else begin
            if (wr_dirb) dirb_q <= wdata;
            if (wr_group) begin
                dirc_q <= wdata[GRP_C_BIT];
                dird_q <= wdata[GRP_D_BIT];
            end
        end
    end

    always_comb begin
        rd_group            = '0;
        rd_group[GRP_C_BIT] = dirc_q;
        rd_group[GRP_D_BIT] = dird_q;
    end

    assign rd_dirb  = dirb_q;
    assign dir_flat = {{PW{dird_q}}, {PW{dirc_q}}, dirb_q, {PW{1'b0}}};
endmodule

// File: rtl/kmp_port_cell.sv
module kmp_port_cell #(
    parameter int W = 4
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] od_low,
    output logic [W-1:0] pu_en,
    output logic [W-1:0] rd_val,
    output logic         low_seen
);
    always_comb begin
        for (int i = 0; i < W; i++) begin
            od_low[i] = dir[i] & ~latch[i];
            pu_en[i]  = ~dir[i];
            rd_val[i] = dir[i] ? latch[i] : pin_sync[i];
        end
        low_seen = |(~dir & ~pin_sync);
    end
endmodule

// File: rtl/keymat_port_bank.sv
module keymat_port_bank
    import kmp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_rf,
    input  logic [BANK_W-1:0]      bus_bank,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [PW-1:0]          bus_wdata,
    output logic [PW-1:0]          bus_rdata,
    input  logic [PINS-1:0]        pin_in,
    output logic [PINS-1:0]        pad_od_low,
    output logic [PINS-1:0]        pad_pu_en,
    output logic                   wake_req
);
    dec_t dec;
    assign dec = decode(bus_rf, bus_bank, bus_addr);

    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] dir_flat;
    logic [PW-1:0]   rd_dirb;
    logic [PW-1:0]   rd_group;
    logic [NPORT-1:0][PW-1:0] lat_q;
    logic [NPORT-1:0][PW-1:0] rd_port;
    logic [NPORT-1:0]         low_seen;

    kmp_sync #(.W(PINS)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    kmp_dir_regs dir_i (
        .clk      (clk),
        .rst      (rst),
        .wr_dirb  (bus_wr & dec.rf_dirb),
        .wr_group (bus_wr & dec.rf_group),
        .wdata    (bus_wdata),
        .dir_flat (dir_flat),
        .rd_dirb  (rd_dirb),
        .rd_group (rd_group)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else begin
            for (int p = 1; p < NPORT; p++) begin
                if (bus_wr && dec.dm_hit && dec.port == port_e'(p))
                    lat_q[p] <= bus_wdata;
            end
            lat_q[0] <= '0;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_cell
        kmp_port_cell #(.W(PW)) cell_i (
            .dir      (dir_flat[p*PW +: PW]),
            .latch    (lat_q[p]),
            .pin_sync (pin_sync[p*PW +: PW]),
            .od_low   (pad_od_low[p*PW +: PW]),
            .pu_en    (pad_pu_en[p*PW +: PW]),
            .rd_val   (rd_port[p]),
            .low_seen (low_seen[p])
        );
    end

    always_comb begin
        if (dec.dm_hit)        bus_rdata = rd_port[dec.port];
        else if (dec.rf_dirb)  bus_rdata = rd_dirb;
        else if (dec.rf_group) bus_rdata = rd_group;
        else                   bus_rdata = '0;
    end

    assign wake_req = |low_seen;
endmodule

// File: rtl/keymat_port_bank_chk.sv
module keymat_port_bank_chk
    import kmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rf,
    input logic [BANK_W-1:0] bus_bank,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PW-1:0]     bus_wdata,
    input logic [PW-1:0]     bus_rdata,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pad_od_low,
    input logic [PINS-1:0]   pad_pu_en,
    input logic              wake_req
);
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_RESET_PADS: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd0) |-> (pad_od_low == 16'hFF00 && pad_pu_en == 16'h00FF)) // R1
        else $error("reset pad state wrong");

    AST_SENSE_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rf && bus_addr == DM_BASE && age_q != 2'd0)
            |=> ($stable(pad_od_low) && $stable(pad_pu_en))) // R2
        else $error("write to sense port changed pads");

    AST_OD_PU_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pad_od_low & pad_pu_en) == '0) // R5
        else $error("pull-up and driver both on");

    AST_GROUP_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rf && bus_addr == RF_GROUP) |-> (bus_rdata[1:0] == 2'b00)) // R4
        else $error("unused group-direction bits nonzero");

    AST_LATCH_TO_PAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rf && bus_bank == '0 && bus_addr == 8'h71)
            |=> (pad_od_low[7:4] == (~pad_pu_en[7:4] & ~$past(bus_wdata)))) // R7
        else $error("latch write not reflected on pads");

    AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (wake_req == |(pad_pu_en & ~$past(pin_in, 2)))) // R8 R9
        else $error("wake request mismatch");
endmodule

bind keymat_port_bank keymat_port_bank_chk chk_i (.*);

// File: tb/keymat_port_bank_tb.sv
module keymat_port_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rf = 1'b0;
    logic [1:0]  bus_bank = '0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_wdata = '0;
    logic [3:0]  bus_rdata;
    logic [15:0] pin_in = 16'hFFFF;
    logic [15:0] pad_od_low;
    logic [15:0] pad_pu_en;
    logic        wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    keymat_port_bank dut_i (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic rf, input logic [1:0] bank, input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_rf = rf; bus_bank = bank; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic rf, input logic [1:0] bank, input logic [7:0] a, output logic [3:0] d);
        bus_wr = 1'b0; bus_rf = rf; bus_bank = bank; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] r;
        logic [15:0] od0, pu0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 od_low", pad_od_low, 16'hFF00);
        check("R1 pu_en", pad_pu_en, 16'h00FF);
        rd(1, 0, 8'h26, r); check("R1 dirB", {12'h0, r}, 16'h0);
        rd(1, 0, 8'h37, r); check("R1 group", {12'h0, r}, 16'hC);
        rd(0, 0, 8'h72, r); check("R1 portC latch", {12'h0, r}, 16'h0);
        check("R1 wake idle", {15'h0, wake_req}, 16'h0);

        // R2 sense port sweep, R6/R9 read of synced pins
        for (int v = 0; v < 16; v++) begin
            pins({12'hFFF, v[3:0]});
            rd(0, 0, 8'h70, r);
            check("R2 portA read", {12'h0, r}, {12'h0, v[3:0]});
            check("R2 portA pads", {pad_od_low[3:0], pad_pu_en[3:0]}, 16'h000F);
        end
        pins(16'hFFFF);
        od0 = pad_od_low; pu0 = pad_pu_en;
        wr(0, 0, 8'h70, 4'h0);
        check("R2 write A nop od", pad_od_low, od0);
        check("R2 write A nop pu", pad_pu_en, pu0);

        // R3 R5 R6 per-bit direction sweep on port B
        wr(0, 0, 8'h71, 4'h5);
        pins(16'hFFAF);
        for (int d = 0; d < 16; d++) begin
            logic [3:0] dv;
            dv = d[3:0];
            wr(1, 0, 8'h26, dv);
            rd(1, 0, 8'h26, r); check("R3 dirB readback", {12'h0, r}, {12'h0, dv});
            rd(0, 0, 8'h71, r);
            check("R6 portB read", {12'h0, r}, {12'h0, (dv & 4'h5) | (~dv & 4'hA)});
            check("R5 portB od", {12'h0, pad_od_low[7:4]}, {12'h0, dv & ~4'h5});
            check("R5 portB pu", {12'h0, pad_pu_en[7:4]}, {12'h0, ~dv});
        end

        // R4 group direction
        wr(1, 0, 8'h37, 4'hF);
        rd(1, 0, 8'h37, r); check("R4 group mask", {12'h0, r}, 16'hC);
        wr(1, 0, 8'h37, 4'h4);
        check("R4 C out D in pu", pad_pu_en[15:8], 16'h00F0);
        wr(1, 0, 8'h37, 4'h0);
        check("R4 C D input pu", pad_pu_en[15:8], 16'h00FF);
        pins(16'h36FF);
        rd(0, 0, 8'h72, r); check("R6 portC pin", {12'h0, r}, 16'h6);
        rd(0, 0, 8'h73, r); check("R6 portD pin", {12'h0, r}, 16'h3);

        // R7 latch write in input mode, then switch to output
        wr(0, 0, 8'h72, 4'h9);
        wr(0, 0, 8'h73, 4'h2);
        check("R7 input mode no drive", pad_od_low[15:8], 16'h0);
        wr(1, 0, 8'h37, 4'hC);
        check("R7 C drive", {12'h0, pad_od_low[11:8]}, 16'h6);
        check("R7 D drive", {12'h0, pad_od_low[15:12]}, 16'hD);
        rd(0, 0, 8'h72, r); check("R6 portC latch", {12'h0, r}, 16'h9);

        // R8 wake sweep: B dir = 0011, C/D outputs
        wr(1, 0, 8'h26, 4'h3);
        for (int v = 0; v < 256; v++) begin
            logic [3:0] a, b;
            logic ew;
            a = v[3:0]; b = v[7:4];
            pins({8'h00, b, a});
            ew = (|(~a)) | (|(~b & 4'hC));
            check("R8 wake", {15'h0, wake_req}, {15'h0, ew});
        end

        // R9 synchronizer latency
        pins(16'hFFFF);
        @(negedge clk); pin_in = 16'hFFF0;
        @(negedge clk);
        rd(0, 0, 8'h70, r); check("R9 one edge old", {12'h0, r}, 16'hF);
        check("R9 wake one edge", {15'h0, wake_req}, 16'h0);
        @(negedge clk);
        rd(0, 0, 8'h70, r); check("R9 two edges new", {12'h0, r}, 16'h0);
        check("R9 wake two edges", {15'h0, wake_req}, 16'h1);
        pins(16'hFFFF);

        // R10 unmapped and other banks
        od0 = pad_od_low; pu0 = pad_pu_en;
        wr(0, 1, 8'h71, 4'h0);
        wr(0, 0, 8'h74, 4'h0);
        wr(1, 0, 8'h27, 4'hF);
        wr(1, 0, 8'h71, 4'h0);
        check("R10 od unchanged", pad_od_low, od0);
        check("R10 pu unchanged", pad_pu_en, pu0);
        rd(0, 1, 8'h72, r); check("R10 bank1 read", {12'h0, r}, 16'h0);
        rd(0, 0, 8'h74, r); check("R10 unmapped read", {12'h0, r}, 16'h0);
        rd(1, 0, 8'h70, r); check("R10 rf 0x70 read", {12'h0, r}, 16'h0);
        rd(0, 0, 8'h72, r); check("R10 latch kept", {12'h0, r}, 16'h9);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule